// File: doc/BRIEF.md
# Run-Time Programmable AND-OR Logic Array

This block evaluates several Boolean functions of a common input vector in sum-of-products form. A set of shared product terms is formed by an AND plane, in which each input may enter a term as a true literal, a complemented literal, or not at all. An OR plane then gathers any subset of those terms into each output. A per-output polarity flag lets an output be delivered either as the OR result or as its complement, so a function can be built from its zeros as easily as from its ones.

Every connection point is a link bit held in a register bank, loaded at run time through a small write port and readable through a separate read address. One write sets a whole product term: its literal row in the AND plane and its fan-out column in the OR plane. The polarity flags have their own write strobe. Outputs are combinational from the inputs and the stored links, so software programs a table once and the array then acts as ordinary logic. The input count, term count and output count are parameters.

Top module: `pla_core`

## Requirements
- R1: For input i, link bit 2i of a term's AND row adds the literal in_vec[i] to that term and link bit 2i+1 adds its complement; with both bits clear the input is absent, and a term is the AND of its present literals.
- R2: A term whose row has both link bits set for any one input evaluates to 0 for every input value.
- R3: A term whose AND row is all zero evaluates to 1.
- R4: Bit j of a term's OR column connects that term to output j, a single term may feed several outputs, and an output with no term connected yields 0 ahead of its polarity stage.
- R5: Polarity flag bit j set delivers output j complemented; clear delivers it unchanged.
- R6: A pulse on cfg_wr_term stores cfg_and_row and cfg_or_col for term cfg_addr at the next rising clock edge; rd_and and rd_or show the stored row of term rd_addr (zero for an address at or beyond the term count), and links are unchanged in cycles without a write.
- R7: A pulse on cfg_wr_inv stores cfg_inv_flags as the polarity flags at the next rising clock edge, independently of term writes; rd_inv shows them.
- R8: A term write whose address is at or beyond the term count changes no link and no output.
- R9: Reset clears every link, so all outputs read 0 and all readback is zero.
- R10: out_vec follows in_vec without any clock edge.
- R11: With inputs A=in_vec[2], B=in_vec[1], C=in_vec[0] and terms AB', AC, BC, both flags clear, output 0 is true exactly on minterms 4, 5, 7 and output 1 on minterms 3, 5, 7.
- R12: With terms B'C', A'C', A'B', ABC, output 0 taking the first three with its flag set and output 1 taking B'C', A'C', ABC with its flag clear, output 0 is true on minterms 3, 5, 6, 7 and output 1 on minterms 0, 2, 4, 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_term | input | 1 | Write strobe for one product term |
| cfg_addr | input | TAW | Index of the term to write |
| cfg_and_row | input | 2*N_IN | AND-plane literal links of the term |
| cfg_or_col | input | N_OUT | OR-plane fan-out links of the term |
| cfg_wr_inv | input | 1 | Write strobe for the polarity flags |
| cfg_inv_flags | input | N_OUT | Polarity flags, one per output |
| rd_addr | input | TAW | Term index for readback |
| rd_and | output | 2*N_IN | Stored AND row of term rd_addr |
| rd_or | output | N_OUT | Stored OR column of term rd_addr |
| rd_inv | output | N_OUT | Stored polarity flags |
| in_vec | input | N_IN | Function inputs |
| out_vec | output | N_OUT | Function outputs |

## Verification
The evaluation path has no register, so outputs and readback are due as soon as inputs settle; the bench changes inputs at a falling edge and samples a time step later, well before the next rising edge. A link write is due one rising edge after its strobe: the bench raises the strobe at a falling edge, samples once before the rising edge to see the old value, then once just after it for the new one. Reset release passes through a two-stage synchronizer, so the bench waits three cycles before its first write.

// File: rtl/pla_pkg.sv
package pla_pkg;
  // Position of the two links of one input inside a term's AND row.
  localparam int LINK_TRUE = 0;
  localparam int LINK_COMP = 1;
  localparam int LINKS_PER_INPUT = 2;

  // One input's contribution to a product term: passes unless a set link
  // demands a literal value the input does not have.
  function automatic logic literal_pass(input logic [1:0] links, input logic x);
    return (~links[LINK_TRUE] | x) & (~links[LINK_COMP] | ~x);
  endfunction
endpackage

// File: rtl/pla_link_bank.sv
module pla_link_bank #(
  parameter int N_IN   = 8,
  parameter int N_TERM = 16,
  parameter int N_OUT  = 4,
  parameter int TAW    = 4,
  parameter int ROW_W  = 2 * N_IN
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_term,
  input  logic [TAW-1:0]            wr_addr,
  input  logic [ROW_W-1:0]          wr_and_row,
  input  logic [N_OUT-1:0]          wr_or_col,
  input  logic                      wr_inv,
  input  logic [N_OUT-1:0]          wr_inv_flags,
  output logic [N_TERM*ROW_W-1:0]   and_links,
  output logic [N_TERM*N_OUT-1:0]   or_links,
  output logic [N_OUT-1:0]          inv_links
);
  logic [N_TERM-1:0] row_en;

  for (genvar t = 0; t < N_TERM; t++) begin : g_row
    logic [ROW_W-1:0] and_q, and_d;
    logic [N_OUT-1:0] or_q, or_d;

    assign row_en[t] = wr_term && (wr_addr == TAW'(t));

    always_comb begin
      and_d = and_q;
      or_d  = or_q;
      if (row_en[t]) begin
        and_d = wr_and_row;
        or_d  = wr_or_col;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        and_q <= '0;
        or_q  <= '0;
      end else begin
        and_q <= and_d;
        or_q  <= or_d;
      end
    end

    assign and_links[t*ROW_W +: ROW_W] = and_q;
    assign or_links[t*N_OUT +: N_OUT]  = or_q;
  end

  logic [N_OUT-1:0] inv_q, inv_d;

  always_comb begin
    inv_d = inv_q;
    if (wr_inv) inv_d = wr_inv_flags;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inv_q <= '0;
    else        inv_q <= inv_d;
  end

  assign inv_links = inv_q;
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int N_TERM = 16,
  parameter int ROW_W  = 2 * N_IN
) (
  input  logic [N_IN-1:0]          in_vec,
  input  logic [N_TERM*ROW_W-1:0]  and_links,
  output logic [N_TERM-1:0]        term_vec
);
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] lit_ok;
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign lit_ok[i] = literal_pass(
        and_links[t*ROW_W + i*LINKS_PER_INPUT +: LINKS_PER_INPUT], in_vec[i]);
    end
    assign term_vec[t] = &lit_ok;
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_TERM = 16,
  parameter int N_OUT  = 4
) (
  input  logic [N_TERM-1:0]        term_vec,
  input  logic [N_TERM*N_OUT-1:0]  or_links,
  input  logic [N_OUT-1:0]         inv_links,
  output logic [N_OUT-1:0]         out_vec
);
  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    logic [N_TERM-1:0] conn;
    logic              sum;
    for (genvar t = 0; t < N_TERM; t++) begin : g_col
      assign conn[t] = or_links[t*N_OUT + j];
    end
    assign sum        = |(term_vec & conn);
    assign out_vec[j] = sum ^ inv_links[j];
  end
endmodule

// File: rtl/pla_core.sv
module pla_core #(
  parameter int N_IN   = 8,
  parameter int N_TERM = 16,
  parameter int N_OUT  = 4,
  parameter int TAW    = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr_term,
  input  logic [TAW-1:0]        cfg_addr,
  input  logic [2*N_IN-1:0]     cfg_and_row,
  input  logic [N_OUT-1:0]      cfg_or_col,
  input  logic                  cfg_wr_inv,
  input  logic [N_OUT-1:0]      cfg_inv_flags,
  input  logic [TAW-1:0]        rd_addr,
  output logic [2*N_IN-1:0]     rd_and,
  output logic [N_OUT-1:0]      rd_or,
  output logic [N_OUT-1:0]      rd_inv,
  input  logic [N_IN-1:0]       in_vec,
  output logic [N_OUT-1:0]      out_vec
);
  localparam int ROW_W = 2 * N_IN;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [N_TERM*ROW_W-1:0] and_links;
  logic [N_TERM*N_OUT-1:0] or_links;
  logic [N_OUT-1:0]        inv_links;
  logic [N_TERM-1:0]       term_vec;

  pla_link_bank #(
    .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .TAW(TAW), .ROW_W(ROW_W)
  ) u_bank (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .wr_term      (cfg_wr_term),
    .wr_addr      (cfg_addr),
    .wr_and_row   (cfg_and_row),
    .wr_or_col    (cfg_or_col),
    .wr_inv       (cfg_wr_inv),
    .wr_inv_flags (cfg_inv_flags),
    .and_links    (and_links),
    .or_links     (or_links),
    .inv_links    (inv_links)
  );

  pla_and_plane #(
    .N_IN(N_IN), .N_TERM(N_TERM), .ROW_W(ROW_W)
  ) u_and (
    .in_vec    (in_vec),
    .and_links (and_links),
    .term_vec  (term_vec)
  );

  pla_or_plane #(
    .N_TERM(N_TERM), .N_OUT(N_OUT)
  ) u_or (
    .term_vec  (term_vec),
    .or_links  (or_links),
    .inv_links (inv_links),
    .out_vec   (out_vec)
  );

  // Readback: an address past the last term selects nothing and reads zero.
  always_comb begin
    rd_and = '0;
    rd_or  = '0;
    for (int t = 0; t < N_TERM; t++) begin
      if (rd_addr == TAW'(t)) begin
        rd_and = and_links[t*ROW_W +: ROW_W];
        rd_or  = or_links[t*N_OUT +: N_OUT];
      end
    end
  end

  assign rd_inv = inv_links;
endmodule

// File: rtl/pla_core_chk.sv
module pla_core_chk #(
  parameter int N_IN   = 8,
  parameter int N_TERM = 16,
  parameter int N_OUT  = 4,
  parameter int TAW    = 4,
  parameter int ROW_W  = 2 * N_IN
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_wr_term,
  input logic [TAW-1:0]           cfg_addr,
  input logic [ROW_W-1:0]         cfg_and_row,
  input logic [N_OUT-1:0]         cfg_or_col,
  input logic                     cfg_wr_inv,
  input logic [N_OUT-1:0]         cfg_inv_flags,
  input logic [N_TERM*ROW_W-1:0]  and_links,
  input logic [N_TERM*N_OUT-1:0]  or_links,
  input logic [N_OUT-1:0]         inv_links,
  input logic [N_OUT-1:0]         out_vec
);
  // R9: while held in reset, every link reads zero.
  p_reset_clear_r9: assert property (@(posedge clk)
    !rst_n |-> (and_links == '0 && or_links == '0 && inv_links == '0));

  // R6: an in-range term write lands on the next edge.
  p_row_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_term && int'(cfg_addr) < N_TERM) |=>
      (and_links[int'($past(cfg_addr))*ROW_W +: ROW_W] == $past(cfg_and_row) &&
       or_links[int'($past(cfg_addr))*N_OUT +: N_OUT] == $past(cfg_or_col)));

  // R6: no write, no change.
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr_term && !cfg_wr_inv) |=>
      ($stable(and_links) && $stable(or_links) && $stable(inv_links)));

  // R7: polarity write lands on the next edge.
  p_inv_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_inv |=> (inv_links == $past(cfg_inv_flags)));

  // R8: out-of-range term write leaves both planes alone.
  p_oob_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_term && int'(cfg_addr) >= N_TERM) |=>
      ($stable(and_links) && $stable(or_links)));

  // R4: with an empty OR plane each output is just its polarity flag.
  p_empty_or_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (or_links == '0) |-> (out_vec == inv_links));
endmodule

bind pla_core pla_core_chk #(
  .N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT), .TAW(TAW), .ROW_W(ROW_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_q),
  .cfg_wr_term   (cfg_wr_term),
  .cfg_addr      (cfg_addr),
  .cfg_and_row   (cfg_and_row),
  .cfg_or_col    (cfg_or_col),
  .cfg_wr_inv    (cfg_wr_inv),
  .cfg_inv_flags (cfg_inv_flags),
  .and_links     (and_links),
  .or_links      (or_links),
  .inv_links     (inv_links),
  .out_vec       (out_vec)
);

// File: tb/tb_pla_core.sv
module tb_pla_core;
  localparam int NI = 3;
  localparam int NT = 5;
  localparam int NO = 2;
  localparam int AW = 3;

  // Program rows {and_row[5:0], or_col[1:0]}: entries 0..2 first table,
  // 3..6 second table. Inputs: A=in[2], B=in[1], C=in[0].
  localparam logic [7:0] PROG [7] = '{
    {6'b011000, 2'b01},   // AB'  -> out0
    {6'b010001, 2'b11},   // AC   -> out0, out1
    {6'b000101, 2'b10},   // BC   -> out1
    {6'b001010, 2'b11},   // B'C' -> both
    {6'b100010, 2'b11},   // A'C' -> both
    {6'b101000, 2'b01},   // A'B' -> out0
    {6'b010101, 2'b10}    // ABC  -> out1
  };
  // Expected minterm masks {out1, out0}.
  localparam logic [15:0] EXP [2] = '{ {8'hA8, 8'hB0}, {8'h95, 8'hE8} };

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr_term, cfg_wr_inv;
  logic [AW-1:0] cfg_addr, rd_addr;
  logic [2*NI-1:0] cfg_and_row, rd_and;
  logic [NO-1:0] cfg_or_col, cfg_inv_flags, rd_or, rd_inv;
  logic [NI-1:0] in_vec;
  logic [NO-1:0] out_vec;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pla_core #(.N_IN(NI), .N_TERM(NT), .N_OUT(NO)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_term(cfg_wr_term), .cfg_addr(cfg_addr),
    .cfg_and_row(cfg_and_row), .cfg_or_col(cfg_or_col),
    .cfg_wr_inv(cfg_wr_inv), .cfg_inv_flags(cfg_inv_flags),
    .rd_addr(rd_addr), .rd_and(rd_and), .rd_or(rd_or), .rd_inv(rd_inv),
    .in_vec(in_vec), .out_vec(out_vec)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_row(int a, logic [5:0] ar, logic [1:0] oc);
    @(negedge clk);
    cfg_wr_term = 1'b1; cfg_addr = AW'(a); cfg_and_row = ar; cfg_or_col = oc;
    @(negedge clk);
    cfg_wr_term = 1'b0;
  endtask

  task automatic wr_inv(logic [1:0] f);
    @(negedge clk);
    cfg_wr_inv = 1'b1; cfg_inv_flags = f;
    @(negedge clk);
    cfg_wr_inv = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Walk all inputs; output j must follow mask j bit by bit.
  task automatic sweep(string req, logic [7:0] m0, logic [7:0] m1);
    for (int v = 0; v < 8; v++) begin
      in_vec = NI'(v);
      #1;
      chk(req, 32'(out_vec), 32'({m1[v], m0[v]}));
    end
  endtask

  initial begin
    rst_n = 1'b1; cfg_wr_term = 1'b0; cfg_wr_inv = 1'b0;
    cfg_addr = '0; cfg_and_row = '0; cfg_or_col = '0; cfg_inv_flags = '0;
    rd_addr = '0; in_vec = '0;
    #5 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: reset state
    sweep("R9 outputs after reset", 8'h00, 8'h00);
    for (int t = 0; t < NT; t++) begin
      rd_addr = AW'(t); #1;
      chk("R9 readback after reset", 32'({rd_and, rd_or}), 32'd0);
    end
    chk("R9 flags after reset", 32'(rd_inv), 32'd0);

    // R11: first program table
    for (int t = 0; t < 3; t++) wr_row(t, PROG[t][7:2], PROG[t][1:0]);
    wr_inv(2'b00);
    sweep("R11 first table", EXP[0][7:0], EXP[0][15:8]);

    // R6: write timing and readback
    rd_addr = 3'd4;
    @(negedge clk);
    cfg_wr_term = 1'b1; cfg_addr = 3'd4; cfg_and_row = 6'b110000; cfg_or_col = 2'b00;
    #1 chk("R6 old value before edge", 32'(rd_and), 32'd0);
    @(posedge clk); #1;
    chk("R6 new value after edge", 32'(rd_and), 32'h30);
    @(negedge clk); cfg_wr_term = 1'b0;

    // R12: second program table (term 4 stays with empty OR column)
    for (int t = 0; t < 4; t++) wr_row(t, PROG[3+t][7:2], PROG[3+t][1:0]);
    wr_inv(2'b01);
    chk("R7 flags readback", 32'(rd_inv), 32'd1);
    sweep("R12 second table", EXP[1][7:0], EXP[1][15:8]);

    // R8: out-of-range writes
    wr_row(5, 6'h3F, 2'b11);
    wr_row(7, 6'h3F, 2'b11);
    for (int t = 0; t < 4; t++) begin
      rd_addr = AW'(t); #1;
      chk("R8 rows kept", 32'({rd_and, rd_or}), 32'(PROG[3+t]));
    end
    rd_addr = 3'd6; #1;
    chk("R6 out-of-range readback zero", 32'({rd_and, rd_or}), 32'd0);
    sweep("R8 outputs kept", EXP[1][7:0], EXP[1][15:8]);

    // R10: output follows input with no clock edge
    @(posedge clk); #3;
    in_vec = 3'd3; #1;
    chk("R10 combinational a", 32'(out_vec), 32'd1);
    in_vec = 3'd0; #1;
    chk("R10 combinational b", 32'(out_vec), 32'd2);

    // Corner cases on a fresh array
    do_reset();
    sweep("R9 outputs after second reset", 8'h00, 8'h00);
    wr_row(0, 6'b000000, 2'b01);
    sweep("R3 empty term is one", 8'hFF, 8'h00);
    wr_row(0, 6'b000001, 2'b01);
    sweep("R1 true literal", 8'hAA, 8'h00);
    wr_row(0, 6'b000010, 2'b01);
    sweep("R1 complement literal", 8'h55, 8'h00);
    wr_row(0, 6'b000011, 2'b01);
    sweep("R2 both links force zero", 8'h00, 8'h00);
    wr_row(0, 6'b000001, 2'b11);
    sweep("R4 shared term", 8'hAA, 8'hAA);
    wr_inv(2'b10);
    sweep("R5 inverted output", 8'hAA, 8'h55);
    wr_row(0, 6'b000001, 2'b00);
    wr_inv(2'b11);
    sweep("R4 empty OR then R5 inversion", 8'hFF, 8'hFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule